// File: doc/BRIEF.md
# Interrupt Source Masking Register File

This block is the programmable front end of a 32-source interrupt controller. It merges hardware request lines with software-raised requests, applies a per-source enable mask and steers every enabled source either to a normal interrupt request or to a fast interrupt request. Both requests are level signals and are registered. Software reaches the block through a simple synchronous bus with one access per cycle.

Enable bits and software request bits are never written directly. Each has a set port and a clear port, so that one source can be changed without a read-modify-write. Route select, protection and test control are plain read/write words. The status words (normal, fast and raw) can only be read.

Read data comes from a two-state response machine. `BUS_IDLE` is the state with no read data pending. `BUS_RDATA` is the state in which a read result is presented. The transitions are:
- `go_read`: `BUS_IDLE` to `BUS_RDATA` when a read is requested.
- `chain_read`: `BUS_RDATA` to `BUS_RDATA` on a back-to-back read.
- `drop_read`: `BUS_RDATA` to `BUS_IDLE` when no read follows.
- `stay_idle`: `BUS_IDLE` to `BUS_IDLE` otherwise.

Writes take effect at the clock edge that samples them and never change the response machine's state.

Top module: `irq_mask_regfile`

## Requirements
- R1: A write to byte offset 0x10 sets every enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x10 returns the enable word.
- R2: A write to offset 0x14 clears every enable bit whose data bit is 1 and leaves the others unchanged.
- R3: A write to 0x18 sets software request bits, and a write to 0x1C clears them, bit by bit for data bits of 1. A read of 0x18 returns the software request word.
- R4: A read of offset 0x08 returns the hardware request lines ORed with the software request word.
- R5: Offset 0x0C holds the route select word and reads back as written. A bit of 1 routes that source to the fast request, and a bit of 0 routes it to the normal request.
- R6: A read of 0x00 returns raw AND enable AND NOT select. A read of 0x04 returns raw AND enable AND select.
- R7: Each clock edge registers the fast and normal requests. The normal request is high exactly when the normal status word was nonzero in the cycle before. The fast request is high exactly when the fast status word was nonzero in the cycle before.
- R8: Offset 0x20 (protection) and offset 0x300 (test control) each store data bit 0. They read back in bit 0, with the upper bits reading as 0.
- R9: Writes to offsets 0x00, 0x04, 0x08 and to any unmapped offset change no state. Reads of 0x14, 0x1C and unmapped offsets return 0.
- R10: Reset clears enable, select, software request, protection and test control, and drives both requests low.
- R11: Read data and its valid flag appear in the cycle after the read is sampled. The valid flag is high for one cycle per read. Read data is 0 whenever the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req_i | input | 32 | Hardware request lines, one per source, high active |
| bus_sel_i | input | 1 | Bus access request in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid, one cycle per read |
| norm_irq_o | output | 1 | Registered normal interrupt request |
| fast_irq_o | output | 1 | Registered fast interrupt request |

## Verification
The assertions assume the following about the inputs:
- The bus carries at most one access per cycle. Set and clear of the same word therefore never share an edge.
- Hardware request lines are synchronous to `clk`.
- `bus_sel_i` is held low during reset.

The stimulus meets these assumptions. It drives every input at the falling edge, issues a single access at a time, and uses hardware request patterns as the only free-running input. The random mix covers writes to read-only and unmapped offsets, so the hold properties are exercised alongside the set/clear properties.

// File: rtl/irqm_pkg.sv
package irqm_pkg;

    localparam int OFS_W = 12;

    localparam logic [OFS_W-1:0] OFS_NSTAT  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_FSTAT  = 12'h004;
    localparam logic [OFS_W-1:0] OFS_RAW    = 12'h008;
    localparam logic [OFS_W-1:0] OFS_ROUTE  = 12'h00C;
    localparam logic [OFS_W-1:0] OFS_EN_SET = 12'h010;
    localparam logic [OFS_W-1:0] OFS_EN_CLR = 12'h014;
    localparam logic [OFS_W-1:0] OFS_SW_SET = 12'h018;
    localparam logic [OFS_W-1:0] OFS_SW_CLR = 12'h01C;
    localparam logic [OFS_W-1:0] OFS_PROT   = 12'h020;
    localparam logic [OFS_W-1:0] OFS_TEST   = 12'h300;

    typedef enum logic [3:0] {
        RS_NSTAT,
        RS_FSTAT,
        RS_RAW,
        RS_ROUTE,
        RS_EN_SET,
        RS_EN_CLR,
        RS_SW_SET,
        RS_SW_CLR,
        RS_PROT,
        RS_TEST,
        RS_NONE
    } reg_sel_e;

    typedef enum logic {
        BUS_IDLE,
        BUS_RDATA
    } bus_state_e;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        reg_sel_e r;
        case (ofs)
            OFS_NSTAT:  r = RS_NSTAT;
            OFS_FSTAT:  r = RS_FSTAT;
            OFS_RAW:    r = RS_RAW;
            OFS_ROUTE:  r = RS_ROUTE;
            OFS_EN_SET: r = RS_EN_SET;
            OFS_EN_CLR: r = RS_EN_CLR;
            OFS_SW_SET: r = RS_SW_SET;
            OFS_SW_CLR: r = RS_SW_CLR;
            OFS_PROT:   r = RS_PROT;
            OFS_TEST:   r = RS_TEST;
            default:    r = RS_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irqm_addr_dec.sv
module irqm_addr_dec #(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]  addr_i,
    output irqm_pkg::reg_sel_e sel_o
);
    import irqm_pkg::*;

    logic hi_zero;

    generate
        if (ADDR_W > OFS_W) begin : g_wide
            assign hi_zero = ~|addr_i[ADDR_W-1:OFS_W];
        end else begin : g_exact
            assign hi_zero = 1'b1;
        end
    endgenerate

    always_comb begin
        if (hi_zero) sel_o = decode_ofs(addr_i[OFS_W-1:0]);
        else         sel_o = RS_NONE;
    end
endmodule

// File: rtl/irqm_ctrl_regs.sv
module irqm_ctrl_regs #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb_i,
    input  irqm_pkg::reg_sel_e reg_sel_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [N_SRC-1:0]   en_o,
    output logic [N_SRC-1:0]   route_o,
    output logic [N_SRC-1:0]   soft_o,
    output logic               prot_o,
    output logic               test_o
);
    import irqm_pkg::*;

    logic [N_SRC-1:0] wsrc;
    assign wsrc = wdata_i[N_SRC-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o    <= '0;
            route_o <= '0;
            soft_o  <= '0;
            prot_o  <= 1'b0;
            test_o  <= 1'b0;
        end else if (wr_stb_i) begin
            case (reg_sel_i)
                RS_EN_SET: en_o    <= en_o | wsrc;
                RS_EN_CLR: en_o    <= en_o & ~wsrc;
                RS_SW_SET: soft_o  <= soft_o | wsrc;
                RS_SW_CLR: soft_o  <= soft_o & ~wsrc;
                RS_ROUTE:  route_o <= wsrc;
                RS_PROT:   prot_o  <= wdata_i[0];
                RS_TEST:   test_o  <= wdata_i[0];
                default: ;
            endcase
        end
    end

    assert_enset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && reg_sel_i == RS_EN_SET) |=>
        (en_o == ($past(en_o) | $past(wsrc))));

    assert_enclr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && reg_sel_i == RS_EN_CLR) |=>
        (en_o == ($past(en_o) & ~$past(wsrc))));

    assert_swset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && reg_sel_i == RS_SW_SET) |=>
        ((soft_o & $past(wsrc)) == $past(wsrc)));

    assert_swclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && reg_sel_i == RS_SW_CLR) |=>
        ((soft_o & $past(wsrc)) == '0));

    assert_ro_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb_i && (reg_sel_i == RS_NSTAT || reg_sel_i == RS_FSTAT ||
                      reg_sel_i == RS_RAW   || reg_sel_i == RS_NONE)) |=>
        ($stable(en_o) && $stable(route_o) && $stable(soft_o) &&
         $stable(prot_o) && $stable(test_o)));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> ($stable(en_o) && $stable(soft_o)));
endmodule

// File: rtl/irqm_status.sv
module irqm_status #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] hw_req_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] route_i,
    input  logic [N_SRC-1:0] soft_i,
    output logic [N_SRC-1:0] raw_o,
    output logic [N_SRC-1:0] nstat_o,
    output logic [N_SRC-1:0] fstat_o,
    output logic             norm_req_o,
    output logic             fast_req_o
);
    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            assign raw_o[g]   = hw_req_i[g] | soft_i[g];
            assign nstat_o[g] = raw_o[g] & en_i[g] & ~route_i[g];
            assign fstat_o[g] = raw_o[g] & en_i[g] &  route_i[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            norm_req_o <= 1'b0;
            fast_req_o <= 1'b0;
        end else begin
            norm_req_o <= |nstat_o;
            fast_req_o <= |fstat_o;
        end
    end

    assert_norm_lvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (norm_req_o == $past(|nstat_o)));

    assert_fast_lvl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (fast_req_o == $past(|fstat_o)));

    assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> (!norm_req_o && !fast_req_o));

    assert_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (route_i == '0) |=> !fast_req_o);
endmodule

// File: rtl/irqm_bus_fsm.sv
module irqm_bus_fsm #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel_i,
    input  logic               bus_wr_i,
    input  irqm_pkg::reg_sel_e reg_sel_i,
    input  logic [N_SRC-1:0]   nstat_i,
    input  logic [N_SRC-1:0]   fstat_i,
    input  logic [N_SRC-1:0]   raw_i,
    input  logic [N_SRC-1:0]   route_i,
    input  logic [N_SRC-1:0]   en_i,
    input  logic [N_SRC-1:0]   soft_i,
    input  logic               prot_i,
    input  logic               test_i,
    output logic               wr_stb_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic               rvalid_o
);
    import irqm_pkg::*;

    bus_state_e state_q, state_d;
    logic        rd_req;
    logic [DATA_W-1:0] rd_mux;

    assign rd_req   = bus_sel_i & ~bus_wr_i;
    assign wr_stb_o = bus_sel_i &  bus_wr_i;

    always_comb begin
        unique case (reg_sel_i)
            RS_NSTAT:  rd_mux = DATA_W'(nstat_i);
            RS_FSTAT:  rd_mux = DATA_W'(fstat_i);
            RS_RAW:    rd_mux = DATA_W'(raw_i);
            RS_ROUTE:  rd_mux = DATA_W'(route_i);
            RS_EN_SET: rd_mux = DATA_W'(en_i);
            RS_SW_SET: rd_mux = DATA_W'(soft_i);
            RS_PROT:   rd_mux = DATA_W'(prot_i);
            RS_TEST:   rd_mux = DATA_W'(test_i);
            default:   rd_mux = '0;
        endcase
    end

    always_comb begin
        unique case (state_q)
            BUS_IDLE:  state_d = rd_req ? BUS_RDATA : BUS_IDLE;
            BUS_RDATA: state_d = rd_req ? BUS_RDATA : BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_o <= '0;
        else if (rd_req) rdata_o <= rd_mux;
        else             rdata_o <= '0;
    end

    assign rvalid_o = (state_q == BUS_RDATA);

    assert_rd_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid_o);

    assert_wr_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sel_i || bus_wr_i) |=> !rvalid_o);

    assert_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> (rdata_o == '0));

    assert_wo_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (reg_sel_i == RS_EN_CLR || reg_sel_i == RS_SW_CLR ||
                    reg_sel_i == RS_NONE)) |=> (rdata_o == '0));
endmodule

// File: rtl/irq_mask_regfile.sv
module irq_mask_regfile #(
    parameter int N_SRC  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  hw_req_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    output logic              norm_irq_o,
    output logic              fast_irq_o
);
    import irqm_pkg::*;

    reg_sel_e         reg_sel;
    logic             wr_stb;
    logic [N_SRC-1:0] en_q, route_q, soft_q, raw, nstat, fstat;
    logic             prot_q, test_q;

    irqm_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (reg_sel)
    );

    irqm_ctrl_regs #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb_i  (wr_stb),
        .reg_sel_i (reg_sel),
        .wdata_i   (bus_wdata_i),
        .en_o      (en_q),
        .route_o   (route_q),
        .soft_o    (soft_q),
        .prot_o    (prot_q),
        .test_o    (test_q)
    );

    irqm_status #(.N_SRC(N_SRC)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_req_i   (hw_req_i),
        .en_i       (en_q),
        .route_i    (route_q),
        .soft_i     (soft_q),
        .raw_o      (raw),
        .nstat_o    (nstat),
        .fstat_o    (fstat),
        .norm_req_o (norm_irq_o),
        .fast_req_o (fast_irq_o)
    );

    irqm_bus_fsm #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel_i (bus_sel_i),
        .bus_wr_i  (bus_wr_i),
        .reg_sel_i (reg_sel),
        .nstat_i   (nstat),
        .fstat_i   (fstat),
        .raw_i     (raw),
        .route_i   (route_q),
        .en_i      (en_q),
        .soft_i    (soft_q),
        .prot_i    (prot_q),
        .test_i    (test_q),
        .wr_stb_o  (wr_stb),
        .rdata_o   (bus_rdata_o),
        .rvalid_o  (bus_rvalid_o)
    );

    assert_reset_low_R10: assert property (@(posedge clk)
        !rst_n |-> (!norm_irq_o && !fast_irq_o && !bus_rvalid_o));
endmodule

// File: tb/irq_mask_regfile_tb.sv
`timescale 1ns/1ps
module irq_mask_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] hw_req;
    logic        bus_sel, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid, norm_irq, fast_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_en, m_route, m_soft, m_hw;
    logic        m_prot, m_test;

    always #5 clk = ~clk;

    irq_mask_regfile u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_req_i     (hw_req),
        .bus_sel_i    (bus_sel),
        .bus_wr_i     (bus_wr),
        .bus_addr_i   (bus_addr),
        .bus_wdata_i  (bus_wdata),
        .bus_rdata_o  (bus_rdata),
        .bus_rvalid_o (bus_rvalid),
        .norm_irq_o   (norm_irq),
        .fast_irq_o   (fast_irq)
    );

    function automatic logic [31:0] m_raw();
        return m_hw | m_soft;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        case (a)
            12'h000: return m_raw() & m_en & ~m_route;
            12'h004: return m_raw() & m_en & m_route;
            12'h008: return m_raw();
            12'h00C: return m_route;
            12'h010: return m_en;
            12'h018: return m_soft;
            12'h020: return {31'd0, m_prot};
            12'h300: return {31'd0, m_test};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        case (a)
            12'h00C: m_route = d;
            12'h010: m_en    = m_en | d;
            12'h014: m_en    = m_en & ~d;
            12'h018: m_soft  = m_soft | d;
            12'h01C: m_soft  = m_soft & ~d;
            12'h020: m_prot  = d[0];
            12'h300: m_test  = d[0];
            default: ;
        endcase
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        chk({req, " R11 rvalid"}, {31'd0, bus_rvalid}, 32'd1);
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic set_hw(input logic [31:0] v);
        @(negedge clk);
        hw_req = v; m_hw = v;
    endtask

    task automatic chk_outs(input string req);
        @(posedge clk);
        @(negedge clk);
        chk({req, " norm"}, {31'd0, norm_irq}, {31'd0, |(m_raw() & m_en & ~m_route)});
        chk({req, " fast"}, {31'd0, fast_irq}, {31'd0, |(m_raw() & m_en & m_route)});
        chk({req, " R11 idle"}, {bus_rdata[30:0], bus_rvalid}, 32'd0);
    endtask

    localparam logic [11:0] OFS_LIST [12] = '{12'h000, 12'h004, 12'h008, 12'h00C,
        12'h010, 12'h014, 12'h018, 12'h01C, 12'h020, 12'h300, 12'h024, 12'h104};

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; hw_req = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        m_en = '0; m_route = '0; m_soft = '0; m_hw = '0; m_prot = 1'b0; m_test = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        chk("R10 norm", {31'd0, norm_irq}, 32'd0);
        chk("R10 fast", {31'd0, fast_irq}, 32'd0);
        rd(12'h010, "R10 enable");
        rd(12'h00C, "R10 route");
        rd(12'h018, "R10 soft");
        rd(12'h020, "R10 prot");
        rd(12'h300, "R10 test");

        // R1 / R2: set and clear of enable bits
        wr(12'h010, 32'hFFFF_0000);
        rd(12'h010, "R1 enable set");
        wr(12'h010, 32'h0000_00F0);
        rd(12'h010, "R1 enable set keeps other bits");
        wr(12'h014, 32'h0F00_0030);
        rd(12'h010, "R2 enable clear");

        // R3: software requests
        wr(12'h018, 32'h8000_0011);
        rd(12'h018, "R3 soft set");
        wr(12'h01C, 32'h0000_0001);
        rd(12'h018, "R3 soft clear");

        // R4: raw combines hardware and software
        set_hw(32'h0001_0200);
        rd(12'h008, "R4 raw");

        // R5 / R6 / R7: routing and masked status
        chk_outs("R7 normal only");
        wr(12'h00C, 32'h8001_0000);
        rd(12'h00C, "R5 route readback");
        rd(12'h000, "R6 normal status");
        rd(12'h004, "R6 fast status");
        chk_outs("R7 both routes");
        wr(12'h014, 32'hFFFF_FFFF);
        chk_outs("R7 all masked");
        wr(12'h010, 32'h8000_0000);
        chk_outs("R5 fast only");

        // R8: protection and test control
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, "R8 prot");
        wr(12'h300, 32'h0000_0003);
        rd(12'h300, "R8 test");

        // R9: read-only and unmapped writes ignored, write-only reads zero
        wr(12'h000, 32'hFFFF_FFFF);
        wr(12'h008, 32'hFFFF_FFFF);
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h010, "R9 enable unchanged");
        rd(12'h018, "R9 soft unchanged");
        rd(12'h00C, "R9 route unchanged");
        rd(12'h014, "R9 enable-clear reads zero");
        rd(12'h01C, "R9 soft-clear reads zero");
        rd(12'h104, "R9 unmapped reads zero");
        chk_outs("R9 outputs unchanged");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 4);
            a  = OFS_LIST[$urandom % 12];
            case (op)
                0: wr(a, $urandom & $urandom);
                1: rd(a, "R6 random read");
                2: set_hw($urandom & $urandom & $urandom);
                default: chk_outs("R7 random");
            endcase
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule